// File: doc/BRIEF.md
# Fracturable Logic Cell

This block is one configurable logic cell. It has eight function inputs, which the documents call a to h. These are bits 0 to 7 of `in_i`. The cell holds a 64-bit lookup mask and a small set of mode bits. Both arrive through a one-bit serial configuration port. The mask can act as one 6-input lookup table. It can also be split into two 32-bit halves that drive two independent 5-input functions, which share inputs c, d and e. A third mode builds a restricted 7-input function by letting input h choose between the two halves. The fourth mode turns the cell into arithmetic: either a 2-bit ripple adder with carry-in and carry-out, or a ternary adder that sums three 2-bit operands.

Each of the two function results feeds its own register. Every register has a clock enable and a synchronous clear. A per-output bypass bit picks the combinational or the registered value for each pin. The lookup is a binary tree of 2:1 multiplexers. The configuration loader is a two-state machine:
- `CFG_IDLE` goes to `CFG_SHIFT` when the shift strobe is seen.
- `CFG_SHIFT` goes back to `CFG_IDLE` when the load strobe commits the shadow word to the active configuration.

Top module: `flc_cell`

## Requirements
- R1: After reset the active configuration is all zero. That means mode 6-LUT, a zero mask, both outputs registered and both registers cleared. So `y_o` is 00 and `cout_o` is 0.
- R2: The configuration word is 69 bits wide. Bits 63:0 are the mask. Bits 65:64 are the mode: 00 is 6-LUT, 01 is split, 10 is 7-input select and 11 is arithmetic. Bit 66 is the bypass for output 0 and bit 67 is the bypass for output 1; a bypass value of 1 means combinational. Bit 68 selects ternary addition. Each cycle with `cfg_shift_i` high shifts `cfg_bit_i` into bit 0 of a shadow word, so the first bit shifted ends up highest. A cycle with `cfg_load_i` high after at least one shift copies the shadow word into the active configuration at that edge and clears the shadow word. A short load therefore fills the upper bits with zeros.
- R3: A load strobe with no shift since the last commit or reset is ignored. The active configuration stays unchanged.
- R4: Mode 00: output 0 is mask[{f,e,d,c,b,a}] and output 1 is input h.
- R5: Mode 01: output 0 is mask[{e,d,c,b,a}] and output 1 is mask[32 + {g,f,e,d,c}].
- R6: Mode 10: output 0 is mask[32 + {g,d,c,b,a}] when h is 1, else mask[{e,d,c,b,a}]. Output 1 is input h.
- R7: Mode 11 with the ternary bit clear: {cout, out1, out0} = {c,a} + {d,b} + h.
- R8: Mode 11 with the ternary bit set: T = {c,a} + {d,b} + {f,e}. The outputs are T[1:0] and `cout_o` is 1 when T is at least 4.
- R9: `cout_o` is 0 in every mode other than 11.
- R10: A register loads its function value on an edge where its enable is 1 and holds it while the enable is 0. A registered output changes only at a clock edge.
- R11: A synchronous clear forces its register to 0 at the next edge, whatever the enable is.
- R12: With its bypass bit at 1, an output follows its function value in the same cycle, whatever the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_shift_i | input | 1 | Shift one configuration bit into the shadow word |
| cfg_bit_i | input | 1 | Serial configuration data |
| cfg_load_i | input | 1 | Commit the shadow word to the active configuration |
| in_i | input | 8 | Function inputs a (bit 0) to h (bit 7) |
| ce_i | input | 2 | Per-register clock enable |
| sclr_i | input | 2 | Per-register synchronous clear |
| y_o | output | 2 | Cell outputs, combinational or registered per bypass bit |
| cout_o | output | 1 | Carry-out of the adder pair |

## Verification
The hardest case to reach is a register that holds a value different from the value its function computes at that moment. Reaching it needs a full serial load into a registered configuration, then a capture with the enable high, and then a change of inputs with the enable low. Only then can holding, clearing and bypass be told apart from the combinational path. The bench walks that sequence with the mixed bypass setting.

The restricted 7-input mode and both adder forms are swept over all 256 input patterns against a model of the equations. A short serial load without the full word, and a load strobe with no shift before it, show that the shadow word is cleared at each commit.

// File: rtl/flc_pkg.sv
package flc_pkg;
    localparam int LUT_K    = 6;
    localparam int MASK_W   = 1 << LUT_K;
    localparam int HALF_K   = LUT_K - 1;
    localparam int HALF_W   = 1 << HALF_K;
    localparam int NUM_IN   = 8;
    localparam int NUM_OUT  = 2;
    localparam int ADD_W    = 2;

    typedef enum logic [1:0] {
        MODE_LUT6  = 2'b00,
        MODE_SPLIT = 2'b01,
        MODE_SEL7  = 2'b10,
        MODE_ARITH = 2'b11
    } flc_mode_e;

    typedef struct packed {
        logic               ternary;
        logic [NUM_OUT-1:0] bypass;
        flc_mode_e          mode;
        logic [MASK_W-1:0]  mask;
    } flc_cfg_t;

    localparam int CFG_W = $bits(flc_cfg_t);
endpackage

// File: rtl/flc_cfg_loader.sv
module flc_cfg_loader
    import flc_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     shift_i,
    input  logic     bit_i,
    input  logic     load_i,
    output flc_cfg_t cfg_o
);
    typedef enum logic {CFG_IDLE, CFG_SHIFT} cfg_state_e;

    cfg_state_e         state_q, state_d;
    logic [CFG_W-1:0]   shadow_q, shadow_next;
    flc_cfg_t           active_q;
    logic               commit;

    assign shadow_next = shift_i ? {shadow_q[CFG_W-2:0], bit_i} : shadow_q;
    assign commit      = (state_q == CFG_SHIFT) && load_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CFG_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE:  if (shift_i) state_d = CFG_SHIFT;
            CFG_SHIFT: if (load_i)  state_d = CFG_IDLE;
            default:                state_d = CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shadow_q <= '0;
            active_q <= '0;
        end else if (commit) begin
            shadow_q <= '0;
            active_q <= flc_cfg_t'(shadow_next);
        end else begin
            shadow_q <= shadow_next;
        end
    end

    assign cfg_o = active_q;

    assert_idle_load_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CFG_IDLE && load_i && !shift_i) |=> $stable(active_q))
        else $error("load in idle changed active configuration");

    assert_commit_copies_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CFG_SHIFT && load_i && !shift_i) |=> (active_q == flc_cfg_t'($past(shadow_q))))
        else $error("commit did not copy shadow word");
endmodule

// File: rtl/flc_lut_tree.sv
module flc_lut_tree #(
    parameter int K = 5
) (
    input  logic [(1<<K)-1:0] mask_i,
    input  logic [K-1:0]      sel_i,
    output logic              y_o
);
    for (genvar l = 0; l < K; l++) begin : g_lvl
        localparam int D = K - 1 - l;
        logic [(1<<D)-1:0] v;
        for (genvar j = 0; j < (1 << D); j++) begin : g_node
            if (l == 0) begin : g_leaf
                assign v[j] = sel_i[l] ? mask_i[2*j+1] : mask_i[2*j];
            end else begin : g_inner
                assign v[j] = sel_i[l] ? g_lvl[l-1].v[2*j+1] : g_lvl[l-1].v[2*j];
            end
        end
    end

    assign y_o = g_lvl[K-1].v[0];
endmodule

// File: rtl/flc_arith.sv
module flc_arith
    import flc_pkg::*;
(
    input  logic [ADD_W-1:0] x_i,
    input  logic [ADD_W-1:0] y_i,
    input  logic [ADD_W-1:0] z_i,
    input  logic             cin_i,
    input  logic             ternary_i,
    output logic [ADD_W-1:0] sum_o,
    output logic             cout_o
);
    logic [ADD_W:0]   rc;
    logic [ADD_W-1:0] rs;
    logic [ADD_W-1:0] cs_s, cs_c;
    logic [ADD_W-1:0] ts;
    logic             tk;

    assign rc[0] = cin_i;
    for (genvar i = 0; i < ADD_W; i++) begin : g_ripple
        assign rs[i]   = x_i[i] ^ y_i[i] ^ rc[i];
        assign rc[i+1] = (x_i[i] & y_i[i]) | (x_i[i] & rc[i]) | (y_i[i] & rc[i]);
        assign cs_s[i] = x_i[i] ^ y_i[i] ^ z_i[i];
        assign cs_c[i] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
    end

    assign ts[0] = cs_s[0];
    assign ts[1] = cs_s[1] ^ cs_c[0];
    assign tk    = cs_s[1] & cs_c[0];

    always_comb begin
        if (ternary_i) begin
            sum_o  = ts;
            cout_o = tk | cs_c[1];
        end else begin
            sum_o  = rs;
            cout_o = rc[ADD_W];
        end
    end
endmodule

// File: rtl/flc_out_reg.sv
module flc_out_reg
    import flc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_OUT-1:0] d_i,
    input  logic [NUM_OUT-1:0] ce_i,
    input  logic [NUM_OUT-1:0] sclr_i,
    input  logic [NUM_OUT-1:0] bypass_i,
    output logic [NUM_OUT-1:0] y_o
);
    logic [NUM_OUT-1:0] q;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)        q[i] <= 1'b0;
            else if (sclr_i[i]) q[i] <= 1'b0;
            else if (ce_i[i])   q[i] <= d_i[i];
        end

        assign y_o[i] = bypass_i[i] ? d_i[i] : q[i];

        assert_sclr_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sclr_i[i] |=> (q[i] == 1'b0))
            else $error("clear did not zero register");

        assert_hold_without_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!ce_i[i] && !sclr_i[i]) |=> (q[i] == $past(q[i])))
            else $error("register changed without enable");

        assert_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ce_i[i] && !sclr_i[i]) |=> (q[i] == $past(d_i[i])))
            else $error("register missed capture");
    end
endmodule

// File: rtl/flc_cell.sv
module flc_cell
    import flc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_shift_i,
    input  logic               cfg_bit_i,
    input  logic               cfg_load_i,
    input  logic [NUM_IN-1:0]  in_i,
    input  logic [NUM_OUT-1:0] ce_i,
    input  logic [NUM_OUT-1:0] sclr_i,
    output logic [NUM_OUT-1:0] y_o,
    output logic               cout_o
);
    flc_cfg_t           cfg;
    logic [HALF_K-1:0]  lo_sel, hi_sel;
    logic               lo_y, hi_y;
    logic [ADD_W-1:0]   sum;
    logic               add_c;
    logic [NUM_OUT-1:0] fn;

    flc_cfg_loader u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (cfg_shift_i),
        .bit_i   (cfg_bit_i),
        .load_i  (cfg_load_i),
        .cfg_o   (cfg)
    );

    assign lo_sel = in_i[4:0];

    always_comb begin
        unique case (cfg.mode)
            MODE_SPLIT: hi_sel = in_i[6:2];
            MODE_SEL7:  hi_sel = {in_i[6], in_i[3:0]};
            default:    hi_sel = in_i[4:0];
        endcase
    end

    flc_lut_tree #(.K(HALF_K)) u_lut_lo (
        .mask_i (cfg.mask[HALF_W-1:0]),
        .sel_i  (lo_sel),
        .y_o    (lo_y)
    );

    flc_lut_tree #(.K(HALF_K)) u_lut_hi (
        .mask_i (cfg.mask[MASK_W-1:HALF_W]),
        .sel_i  (hi_sel),
        .y_o    (hi_y)
    );

    flc_arith u_arith (
        .x_i       ({in_i[2], in_i[0]}),
        .y_i       ({in_i[3], in_i[1]}),
        .z_i       ({in_i[5], in_i[4]}),
        .cin_i     (in_i[7]),
        .ternary_i (cfg.ternary),
        .sum_o     (sum),
        .cout_o    (add_c)
    );

    always_comb begin
        unique case (cfg.mode)
            MODE_LUT6:  fn = {in_i[7], in_i[5] ? hi_y : lo_y};
            MODE_SPLIT: fn = {hi_y, lo_y};
            MODE_SEL7:  fn = {in_i[7], in_i[7] ? hi_y : lo_y};
            MODE_ARITH: fn = sum;
            default:    fn = '0;
        endcase
    end

    assign cout_o = (cfg.mode == MODE_ARITH) ? add_c : 1'b0;

    flc_out_reg u_out (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .d_i      (fn),
        .ce_i     (ce_i),
        .sclr_i   (sclr_i),
        .bypass_i (cfg.bypass),
        .y_o      (y_o)
    );

    assert_cout_only_arith_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg.mode != MODE_ARITH) |-> !cout_o)
        else $error("carry out outside arithmetic mode");

    assert_bypass_follows_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg.bypass[1] |-> (y_o[1] == fn[1]))
        else $error("bypassed output 1 not combinational");
endmodule

// File: tb/flc_cell_bench.sv
`timescale 1ns/1ps
module flc_cell_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_shift = 1'b0, cfg_bit = 1'b0, cfg_load = 1'b0;
    logic [7:0] in_v = '0;
    logic [1:0] ce = '0, sclr = '0;
    logic [1:0] y;
    logic       cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    flc_cell u_flc_cell (
        .clk_i(clk), .rst_ni(rst_n), .cfg_shift_i(cfg_shift), .cfg_bit_i(cfg_bit),
        .cfg_load_i(cfg_load), .in_i(in_v), .ce_i(ce), .sclr_i(sclr),
        .y_o(y), .cout_o(cout)
    );

    typedef struct {
        logic [2:0] exp;
        string      req;
    } item_t;

    item_t    sb_q[$];
    event     sb_ev;
    logic [68:0] m_cfg = '0;
    logic [1:0]  m_reg = '0;

    function automatic logic [2:0] model(logic [68:0] w, logic [7:0] v);
        logic [63:0] mk;
        logic [1:0]  md;
        logic [3:0]  t;
        logic        f0, f1, c;
        mk = w[63:0];
        md = w[65:64];
        c  = 1'b0;
        case (md)
            2'b00: begin f0 = mk[v[5:0]]; f1 = v[7]; end
            2'b01: begin f0 = mk[v[4:0]]; f1 = mk[32 + int'(v[6:2])]; end
            2'b10: begin
                f0 = v[7] ? mk[32 + int'({v[6], v[3:0]})] : mk[v[4:0]];
                f1 = v[7];
            end
            default: begin
                if (w[68]) begin
                    t = 4'({v[2], v[0]}) + 4'({v[3], v[1]}) + 4'({v[5], v[4]});
                    c = (t >= 4);
                end else begin
                    t = 4'({v[2], v[0]}) + 4'({v[3], v[1]}) + 4'(v[7]);
                    c = t[2];
                end
                f0 = t[0];
                f1 = t[1];
            end
        endcase
        return {c, f1, f0};
    endfunction

    function automatic logic [2:0] expect_now(logic [7:0] v);
        logic [2:0] m;
        logic [1:0] yy;
        m = model(m_cfg, v);
        yy[0] = m_cfg[66] ? m[0] : m_reg[0];
        yy[1] = m_cfg[67] ? m[1] : m_reg[1];
        return {m[2], yy};
    endfunction

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if ({cout, y} !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got cout,y=%b expected %b in=%h", it.req, {cout, y}, it.exp, in_v);
                end
            end
        end
    end

    // driver: apply inputs, queue expected value, then clock one edge
    task automatic step(logic [7:0] v, logic [1:0] e, logic [1:0] s, string req);
        logic [2:0] m;
        item_t it;
        @(negedge clk);
        in_v = v; ce = e; sclr = s;
        #1;
        it.exp = expect_now(v);
        it.req = req;
        sb_q.push_back(it);
        -> sb_ev;
        m = model(m_cfg, v);
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            if (s[i])      m_reg[i] = 1'b0;
            else if (e[i]) m_reg[i] = m[i];
        end
    endtask

    task automatic load_cfg(logic [68:0] w);
        for (int i = 68; i >= 0; i--) begin
            @(negedge clk);
            cfg_shift = 1'b1; cfg_bit = w[i]; ce = '0; sclr = '0;
        end
        @(negedge clk);
        cfg_shift = 1'b0; cfg_load = 1'b1;
        @(posedge clk);
        m_cfg = w;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    function automatic logic [68:0] word(logic t, logic [1:0] b, logic [1:0] md, logic [63:0] mk);
        return {t, b, md, mk};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired before the run completed");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    localparam logic [63:0] MK = 64'hA5C3_1E7F_0F96_3C5A;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(8'hFF, 2'b00, 2'b00, "R1");
        step(8'hFF, 2'b11, 2'b00, "R1");

        // R4 and R9: whole mask as one 6-input table
        load_cfg(word(1'b0, 2'b11, 2'b00, MK));
        for (int v = 0; v < 256; v++) step(8'(v), 2'b00, 2'b00, "R4");
        // R5: split halves
        load_cfg(word(1'b0, 2'b11, 2'b01, MK));
        for (int v = 0; v < 256; v++) step(8'(v), 2'b00, 2'b00, "R5");
        // R6: restricted 7-input select
        load_cfg(word(1'b0, 2'b11, 2'b10, MK));
        for (int v = 0; v < 256; v++) step(8'(v), 2'b00, 2'b00, "R6");
        // R7: binary adder with carry in and out
        load_cfg(word(1'b0, 2'b11, 2'b11, MK));
        for (int v = 0; v < 256; v++) step(8'(v), 2'b00, 2'b00, "R7");
        // R8: ternary adder
        load_cfg(word(1'b1, 2'b11, 2'b11, MK));
        for (int v = 0; v < 256; v++) step(8'(v), 2'b00, 2'b00, "R8");

        // R3: load strobe without shift leaves the ternary config in place
        @(negedge clk); cfg_load = 1'b1;
        @(posedge clk);
        @(negedge clk); cfg_load = 1'b0;
        step(8'h3F, 2'b00, 2'b00, "R3");
        step(8'h2D, 2'b00, 2'b00, "R3");
        step(8'h1B, 2'b00, 2'b00, "R3");

        // R10: registered outputs, split mode, no bypass
        load_cfg(word(1'b0, 2'b00, 2'b01, MK));
        step(8'h00, 2'b11, 2'b00, "R10");
        step(8'h5C, 2'b11, 2'b00, "R10");
        step(8'hA3, 2'b00, 2'b00, "R10");
        step(8'h17, 2'b00, 2'b00, "R10");
        step(8'hE9, 2'b01, 2'b00, "R10");
        step(8'h42, 2'b10, 2'b00, "R10");
        step(8'h42, 2'b00, 2'b00, "R10");

        // R11: clear wins over enable and without enable
        load_cfg(word(1'b0, 2'b00, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF));
        step(8'h11, 2'b11, 2'b00, "R11");
        step(8'h22, 2'b00, 2'b11, "R11");
        step(8'h33, 2'b11, 2'b00, "R11");
        step(8'h44, 2'b11, 2'b01, "R11");
        step(8'h55, 2'b00, 2'b00, "R11");

        // R12: output 1 bypassed, output 0 registered
        load_cfg(word(1'b0, 2'b10, 2'b01, MK));
        step(8'h00, 2'b11, 2'b00, "R12");
        step(8'hF0, 2'b00, 2'b00, "R12");
        step(8'h0F, 2'b00, 2'b11, "R12");
        step(8'h96, 2'b00, 2'b00, "R12");
        step(8'h69, 2'b11, 2'b00, "R12");
        step(8'h69, 2'b00, 2'b00, "R12");

        // R2: short load of three bits gives mask bits 0 and 2, rest zero
        @(negedge clk); cfg_shift = 1'b1; cfg_bit = 1'b1;
        @(negedge clk); cfg_bit = 1'b0;
        @(negedge clk); cfg_bit = 1'b1;
        @(negedge clk); cfg_shift = 1'b0; cfg_load = 1'b1;
        @(posedge clk);
        m_cfg = 69'd5;
        @(negedge clk); cfg_load = 1'b0;
        step(8'h00, 2'b11, 2'b00, "R2");
        step(8'h81, 2'b11, 2'b00, "R2");
        step(8'h02, 2'b11, 2'b00, "R2");
        step(8'h04, 2'b11, 2'b00, "R2");
        step(8'h00, 2'b00, 2'b00, "R2");

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule